// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host-side reader for a delta-sigma converter that returns one 32-bit frame per conversion over a three-wire serial link. On a start request it pulls the active-low chip select low and watches the data line. While a conversion is still running the converter drives that line high. The reader generates no serial clock edge until it sees the line low. It then produces a serial clock that idles low and has a programmable half period, and it captures 32 bits, most significant first.

The captured frame is split into a channel bit, a sign flag, an extended-range flag, a 24-bit magnitude field and four sub-LSB bits. A 25-bit two's-complement result is also built from the sign flag and the magnitude field, with over-range and under-range inputs clamped to the ends of the scale. The decoded frame is offered on a valid/ready pair. It is held until the consumer accepts it, and no new read starts while it is held.

Two error paths exist. If the busy level never drops within a programmable number of cycles, the reader deselects the device, pulses a timeout flag and goes idle. If the first captured bit reads high, the frame is discarded and a frame-error pulse is given instead of valid data.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, and out_valid, timeout_flag and frame_err are 0.
- R2: A start while idle with no held output drives cs_n low. sck stays low for as long as sdo reads high after that.
- R3: sck idles low. Each high phase lasts exactly max(clk_div, 2) system clock cycles.
- R4: A frame has exactly 32 sck rising edges. sdo is sampled at the system clock edge that raises sck, so the first sample is frame bit 31. Bits enter MSB first. cs_n returns high at the sck falling edge that follows the 32nd rise.
- R5: The frame is decoded with bit 30 as out_chan, bit 29 as out_sign, bit 28 as out_range, bits 27..4 as out_result and bits 3..0 as out_sub.
- R6: When out_range is 0, out_signed equals {~out_sign, out_result}. Read as two's complement, a sign flag of 1 gives +result and a sign flag of 0 gives result − 2^24.
- R7: Sign 1 with range 1 sets out_over and gives out_signed = 0x0FFFFFF. Sign 0 with range 1 sets out_under and gives out_signed = 0x1000000. out_over and out_under are never both 1.
- R8: If sdo stays high, timeout_flag pulses for one cycle exactly max(timeout_cycles, 1) cycles after cs_n falls. cs_n rises in that same cycle, no sck edge occurs and out_valid stays 0.
- R9: A frame whose captured bit 31 is 1 gives a one-cycle frame_err pulse, with cs_n high and out_valid 0.
- R10: While out_valid is 1 and out_ready is 0, out_valid and every decoded field hold their values, and start is ignored (cs_n stays 1). out_ready with out_valid clears out_valid at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one frame read |
| clk_div | input | DIV_W | sck half period in system clocks (values below 2 act as 2) |
| timeout_cycles | input | TO_W | Longest wait for the busy level to drop |
| cs_n | output | 1 | Active-low device select |
| sck | output | 1 | Serial clock, idles low |
| sdo | input | 1 | Serial data from the converter |
| out_valid | output | 1 | Decoded frame available |
| out_ready | input | 1 | Consumer accepts the frame |
| out_chan | output | 1 | Channel bit |
| out_sign | output | 1 | Sign flag |
| out_range | output | 1 | Extended-range flag |
| out_result | output | DATA_W | Magnitude field |
| out_sub | output | SUB_W | Sub-LSB bits |
| out_signed | output | DATA_W+1 | Saturated two's-complement result |
| out_over | output | 1 | Input above full scale |
| out_under | output | 1 | Input below zero |
| timeout_flag | output | 1 | One-cycle pulse on busy timeout |
| frame_err | output | 1 | One-cycle pulse on a bad first bit |

## Verification
The bench uses the default widths: an 8-bit divider, a 16-bit timeout, a 24-bit field and 4 sub-LSB bits. It sweeps clk_div over 0, 1, 2, 3, 4 and 7, which covers both clamped settings and several odd and even half periods. For each divider it runs all eight combinations of channel, sign and range with two computed magnitude patterns, including all-zero and all-one fields, so every saturation branch and both signed conversions are reached at every clock speed. Timeouts of 1, 20 and 37 cycles and an early-falling busy level, which forces a high first bit, exercise the two error paths.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int STAT_BITS = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SHIFT} rd_state_t;
endpackage

// File: rtl/adc_rd_sck_gen.sv
module adc_rd_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] clk_div,
  output logic             sck,
  output logic             rise_now,
  output logic             fall_now
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic             last;

  assign half = (clk_div < DIV_W'(2)) ? DIV_W'(2) : clk_div;
  assign last = (cnt == half - DIV_W'(1));
  assign rise_now = run && last && !sck;
  assign fall_now = run && last && sck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sck);
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int N = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       take,
  input  logic                       din,
  output logic [N-1:0]               word,
  output logic [$clog2(N+1)-1:0]     count
);
  localparam int CW = $clog2(N+1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      word  <= '0;
      count <= '0;
    end else if (take) begin
      word  <= {word[N-2:0], din};
      count <= count + CW'(1);
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(N));
  a_r4_no_extra_bit: assert property (@(posedge clk) disable iff (rst)
    take |-> count < CW'(N));
endmodule

// File: rtl/adc_rd_decode.sv
module adc_rd_decode #(
  parameter int DATA_W = 24,
  parameter int SUB_W  = 4
) (
  input  logic [adc_rd_pkg::STAT_BITS+DATA_W+SUB_W-1:0] word,
  output logic                chan,
  output logic                sign,
  output logic                rng,
  output logic [DATA_W-1:0]   result,
  output logic [SUB_W-1:0]    sub,
  output logic [DATA_W:0]     signed_val,
  output logic                over,
  output logic                under
);
  localparam int N = adc_rd_pkg::STAT_BITS + DATA_W + SUB_W;

  assign chan   = word[N-2];
  assign sign   = word[N-3];
  assign rng    = word[N-4];
  assign result = word[SUB_W +: DATA_W];
  assign sub    = word[SUB_W-1:0];
  assign over   = rng && sign;
  assign under  = rng && !sign;

  always_comb begin
    if (over)       signed_val = {1'b0, {DATA_W{1'b1}}};
    else if (under) signed_val = {1'b1, {DATA_W{1'b0}}};
    else            signed_val = {~sign, result};
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV_W  = 8,
  parameter int TO_W   = 16,
  parameter int DATA_W = 24,
  parameter int SUB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [TO_W-1:0]   timeout_cycles,
  output logic              cs_n,
  output logic              sck,
  input  logic              sdo,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_chan,
  output logic              out_sign,
  output logic              out_range,
  output logic [DATA_W-1:0] out_result,
  output logic [SUB_W-1:0]  out_sub,
  output logic [DATA_W:0]   out_signed,
  output logic              out_over,
  output logic              out_under,
  output logic              timeout_flag,
  output logic              frame_err
);
  import adc_rd_pkg::*;

  localparam int N  = STAT_BITS + DATA_W + SUB_W;
  localparam int CW = $clog2(N+1);

  rd_state_t       state;
  logic [TO_W-1:0] wcnt;
  logic            run, rise_now, fall_now, done;
  logic [N-1:0]    word;
  logic [CW-1:0]   count;

  logic              d_chan, d_sign, d_rng, d_over, d_under;
  logic [DATA_W-1:0] d_result;
  logic [SUB_W-1:0]  d_sub;
  logic [DATA_W:0]   d_signed;

  assign run  = (state == ST_SHIFT);
  assign done = fall_now && (count == CW'(N));

  adc_rd_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk(clk), .rst(rst), .run(run), .clk_div(clk_div),
    .sck(sck), .rise_now(rise_now), .fall_now(fall_now)
  );

  adc_rd_shifter #(.N(N)) u_shift (
    .clk(clk), .rst(rst), .clear(!run), .take(rise_now), .din(sdo),
    .word(word), .count(count)
  );

  adc_rd_decode #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_dec (
    .word(word), .chan(d_chan), .sign(d_sign), .rng(d_rng),
    .result(d_result), .sub(d_sub), .signed_val(d_signed),
    .over(d_over), .under(d_under)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cs_n         <= 1'b1;
      wcnt         <= '0;
      out_valid    <= 1'b0;
      out_chan     <= 1'b0;
      out_sign     <= 1'b0;
      out_range    <= 1'b0;
      out_result   <= '0;
      out_sub      <= '0;
      out_signed   <= '0;
      out_over     <= 1'b0;
      out_under    <= 1'b0;
      timeout_flag <= 1'b0;
      frame_err    <= 1'b0;
    end else begin
      timeout_flag <= 1'b0;
      frame_err    <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start && !out_valid) begin
            cs_n  <= 1'b0;
            wcnt  <= '0;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!sdo) begin
            state <= ST_SHIFT;
          end else if (({1'b0, wcnt} + (TO_W+1)'(1)) >= {1'b0, timeout_cycles}) begin
            cs_n         <= 1'b1;
            timeout_flag <= 1'b1;
            state        <= ST_IDLE;
          end else begin
            wcnt <= wcnt + TO_W'(1);
          end
        end
        ST_SHIFT: begin
          if (done) begin
            cs_n  <= 1'b1;
            state <= ST_IDLE;
            if (word[N-1]) begin
              frame_err <= 1'b1;
            end else begin
              out_valid  <= 1'b1;
              out_chan   <= d_chan;
              out_sign   <= d_sign;
              out_range  <= d_rng;
              out_result <= d_result;
              out_sub    <= d_sub;
              out_signed <= d_signed;
              out_over   <= d_over;
              out_under  <= d_under;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_no_sck_while_busy: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !sck);
  a_r3_sck_only_selected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_over, out_under}));
  a_r8_timeout_deselects: assert property (@(posedge clk) disable iff (rst)
    timeout_flag |-> (cs_n && !out_valid));
  a_r9_error_no_valid: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> (cs_n && !out_valid));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_signed)
      && $stable(out_result) && $stable(out_sub) && $stable(out_chan)));
endmodule

// File: tb/adc_frame_reader_test.sv
`timescale 1ns/1ps
module adc_frame_reader_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  clk_div = 8'd2;
  logic [15:0] timeout_cycles = 16'd1000;
  logic        cs_n, sck, sdo;
  logic        out_valid, out_ready = 1'b0;
  logic        out_chan, out_sign, out_range, out_over, out_under;
  logic [23:0] out_result;
  logic [3:0]  out_sub;
  logic [24:0] out_signed;
  logic        timeout_flag, frame_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  adc_frame_reader uut (
    .clk(clk), .rst(rst), .start(start), .clk_div(clk_div),
    .timeout_cycles(timeout_cycles), .cs_n(cs_n), .sck(sck), .sdo(sdo),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .out_sign(out_sign), .out_range(out_range), .out_result(out_result),
    .out_sub(out_sub), .out_signed(out_signed), .out_over(out_over),
    .out_under(out_under), .timeout_flag(timeout_flag), .frame_err(frame_err)
  );

  // converter model
  logic        busy = 1'b1;
  logic [31:0] frame = '0;
  int          idx = 0;
  always @(negedge sck or posedge cs_n) begin
    if (cs_n) idx <= 0;
    else if (idx < 31) idx <= idx + 1;
  end
  assign sdo = (cs_n !== 1'b0) ? 1'b1 : (idx == 0 ? busy : frame[31-idx]);

  // monitor, sampled away from the active edge
  int   exp_half = 2;
  int   hlen = 0, hp_bad = 0, rises = 0;
  logic sck_q = 1'b0;
  always @(negedge clk) begin
    if (sck === 1'b1 && sck_q !== 1'b1) rises = rises + 1;
    if (sck === 1'b1) hlen = hlen + 1;
    if (sck !== 1'b1 && sck_q === 1'b1) begin
      if (hlen != exp_half) hp_bad = hp_bad + 1;
      hlen = 0;
    end
    sck_q = sck;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic run_frame(input int div, input bit ch, input bit sg, input bit rg,
                           input logic [23:0] res, input logic [3:0] sb);
    longint e;
    int     n;
    logic [24:0] held_s;
    logic [23:0] held_r;
    clk_div = 8'(div);
    exp_half = (div < 2) ? 2 : div;
    frame = {1'b0, ch, sg, rg, res, sb};
    busy = 1'b1;
    timeout_cycles = 16'd1000;
    @(negedge clk);
    rises = 0; hp_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(cs_n == 1'b0, "R2", "cs_n low after start", cs_n, 0);
    chk(rises == 0 && sck == 1'b0, "R2", "no sck while busy", rises, 0);
    busy = 1'b0;
    n = 0;
    while (!out_valid && n < 3000) begin @(negedge clk); n++; end
    chk(out_valid == 1'b1, "R4", "frame completed", out_valid, 1);
    chk(rises == 32, "R4", "rising edges per frame", rises, 32);
    chk(cs_n == 1'b1, "R4", "cs_n high after frame", cs_n, 1);
    chk(hp_bad == 0, "R3", "sck high phase length errors", hp_bad, 0);
    chk({out_chan, out_sign, out_range} == {ch, sg, rg}, "R5", "status bits",
        {out_chan, out_sign, out_range}, {ch, sg, rg});
    chk(out_result == res, "R5", "result field", out_result, res);
    chk(out_sub == sb, "R5", "sub field", out_sub, sb);
    if (rg && sg)  e = (64'sd1 <<< 24) - 1;
    else if (rg)   e = -(64'sd1 <<< 24);
    else if (sg)   e = longint'(res);
    else           e = longint'(res) - (64'sd1 <<< 24);
    chk(longint'($signed(out_signed)) == e, rg ? "R7" : "R6", "signed value",
        longint'($signed(out_signed)), e);
    chk(out_over == (rg && sg) && out_under == (rg && !sg), "R7", "range flags",
        {out_over, out_under}, {rg && sg, rg && !sg});
    held_s = out_signed; held_r = out_result;
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    chk(out_valid && cs_n && out_signed == held_s && out_result == held_r, "R10",
        "held output, start ignored", {out_valid, cs_n}, 3);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R10", "valid cleared on ready", out_valid, 0);
  endtask

  task automatic run_timeout(input int t);
    int n;
    int tt;
    tt = (t < 1) ? 1 : t;
    clk_div = 8'd2;
    busy = 1'b1;
    timeout_cycles = 16'(t);
    @(negedge clk);
    rises = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!timeout_flag && n < 500) begin @(negedge clk); n++; end
    chk(n == tt, "R8", "timeout delay", n, tt);
    chk(cs_n == 1'b1 && out_valid == 1'b0 && rises == 0, "R8",
        "deselect without data", {cs_n, out_valid}, 2);
    @(negedge clk);
    chk(timeout_flag == 1'b0, "R8", "timeout pulse width", timeout_flag, 0);
  endtask

  task automatic run_bad_first_bit;
    int n;
    clk_div = 8'd3;
    exp_half = 3;
    frame = 32'h5123_4567;
    busy = 1'b1;
    timeout_cycles = 16'd1000;
    @(negedge clk);
    rises = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
    busy = 1'b1;
    n = 0;
    while (!frame_err && n < 3000) begin @(negedge clk); n++; end
    chk(frame_err == 1'b1, "R9", "frame error pulse", frame_err, 1);
    chk(cs_n == 1'b1 && out_valid == 1'b0, "R9", "no valid on error",
        {cs_n, out_valid}, 2);
    chk(rises == 32, "R9", "full frame clocked", rises, 32);
    @(negedge clk);
    chk(frame_err == 1'b0 && out_valid == 1'b0, "R9", "pulse width",
        {frame_err, out_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int divs[6] = '{0, 1, 2, 3, 4, 7};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1", "reset pins", {cs_n, sck}, 2);
    chk(out_valid == 1'b0 && timeout_flag == 1'b0 && frame_err == 1'b0, "R1",
        "reset flags", {out_valid, timeout_flag, frame_err}, 0);
    foreach (divs[i]) begin
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < 2; k++) begin
          logic [23:0] r;
          r = 24'(divs[i] * 32'h3A5C1 + c * 32'h1F3D7 + k * 32'hB0B0B5);
          if (k == 0 && c == 0) r = 24'h000000;
          if (k == 1 && c == 7) r = 24'hFFFFFF;
          run_frame(divs[i], c[2], c[1], c[0], r, 4'(c * 3 + k * 5));
        end
      end
    end
    run_timeout(1);
    run_timeout(20);
    run_timeout(37);
    run_bad_first_bit();
    run_frame(2, 1'b1, 1'b0, 1'b0, 24'h800001, 4'hA);
    summary();
  end
endmodule